// File: doc/BRIEF.md
# NAND Flash Bank Access Front End

This block sits between a simple processor bus and the pins of up to four NAND flash devices. Software drives chip enables and write protect through a control register, and it sets strobe timing through a timing register. It then moves single bytes to or from the flash by accessing small per-bank address windows. Each window offers three locations. One issues a plain data cycle, one issues an address-latch cycle and one issues a command-latch cycle. The block produces the latch enables, the write and read strobes and the data drive, and it lengthens each phase by the programmed clock counts.

A bus access is presented with `bus_valid` and held until `bus_ready` pulses for one clock. Register accesses complete on the clock after acceptance. Flash accesses stall the handshake until the whole setup, strobe and hold sequence has run. An access to a window whose chip-enable bit is clear finishes at once without any strobe. The flash ready/busy pin is resynchronised before software can see it.

Top module: `nand_bus_front`

## Requirements
- R1: After reset, every `flash_ce_n` bit is 1, `flash_wp` is 0, CLE and ALE are 0, both strobes are high, the data drive is off, and the timing register reads 0x1081.
- R2: The control register sits at offset 0x000. Bits [7:0] are a one-hot chip-enable field that reads back as written. Bit n (n < 4) set drives `flash_ce_n[n]` low. Bit 8 drives `flash_wp` and reads back.
- R3: Control bit 9 is read-only and reflects `flash_rb` through two clock stages. A read accepted on the first edge after a change still returns the old level. Writes to bit 9 have no effect.
- R4: The timing register sits at offset 0x004 and reads back bits [17:0]. Bits [5:0] give setup clocks, [11:6] strobe-low clocks and [17:12] hold clocks. A field of zero counts as one clock.
- R5: A write to bank offset 0x8 (bank n window at 0x800 + n*0x100) raises CLE for the setup, strobe and hold phases. It pulls `flash_we_n` low only for the strobe phase and drives the low byte of the written word on the data pins.
- R6: A write to bank offset 0x4 behaves as R5 but raises ALE instead of CLE.
- R7: A write to bank offset 0x0 behaves as R5 with neither CLE nor ALE raised.
- R8: A read of bank offset 0x0 pulls `flash_re_n` low for the strobe phase with the data drive off. It returns, in bits [7:0] with zero above, the byte present when `flash_re_n` rises.
- R9: `bus_ready` is high for exactly one clock per access. That clock comes right after acceptance for register, unmapped or disabled-bank accesses, and right after the last hold clock for flash cycles.
- R10: An access to a bank whose chip-enable bit is clear toggles no strobe or latch signal. A read of it returns 0xFF.
- R11: Reads of unmapped offsets (including unused offsets inside a bank window) return 0. Writes to them change no register and toggle no flash signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-clock completion pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| flash_ce_n | output | 4 | Active-low chip enables, one per bank |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_we_n | output | 1 | Active-low write strobe |
| flash_re_n | output | 1 | Active-low read strobe |
| flash_wp | output | 1 | Write-protect level from control bit 8 |
| flash_dq_out | output | 8 | Data toward the flash |
| flash_dq_oe | output | 1 | Drive enable for `flash_dq_out` |
| flash_dq_in | input | 8 | Data from the flash |
| flash_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
A phase counter that loads the wrong count or skips a phase shows at once as a strobe pulse of the wrong width, or as CLE or ALE dropping early. The per-clock pin comparison catches this in the first clock of the affected phase. A wrong access-state register shows as `bus_ready` arriving early, arriving late or lasting two clocks, all within the access that causes it. A stale chip-enable or write-protect bit appears on the pins on the clock after the control write. A synchroniser of the wrong depth is caught by the read issued on the first edge after a ready change.

// File: rtl/nand_front_pkg.sv
package nand_front_pkg;

  localparam int CTRL_OFS   = 'h000;
  localparam int TIMING_OFS = 'h004;
  localparam int WIN_BASE   = 'h800;
  localparam int WIN_SHIFT  = 8;
  localparam int WIN_SPAN   = 1 << WIN_SHIFT;
  localparam int SUB_DATA   = 'h0;
  localparam int SUB_ADDR   = 'h4;
  localparam int SUB_CMD    = 'h8;
  localparam int TFIELD_W   = 6;
  localparam int TIMING_W   = 3 * TFIELD_W;

  typedef enum logic [1:0] {AC_NONE, AC_CTRL, AC_TIMING, AC_FLASH} acc_t;
  typedef enum logic [1:0] {XK_DATA, XK_ADDR, XK_CMD} xfer_kind_t;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

  typedef struct packed {
    logic [TFIELD_W-1:0] hold;
    logic [TFIELD_W-1:0] strobe;
    logic [TFIELD_W-1:0] setup;
  } timing_t;

endpackage

// File: rtl/nand_win_decode.sv
module nand_win_decode
  import nand_front_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc,
  output xfer_kind_t        kind,
  output logic [BANK_W-1:0] bank
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(TIMING_OFS);
  localparam logic [ADDR_W-1:0] A_WBASE  = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] A_WEND   = ADDR_W'(WIN_BASE + NUM_BANKS * WIN_SPAN);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel  = addr - A_WBASE;
    acc  = AC_NONE;
    kind = XK_DATA;
    bank = BANK_W'(rel >> WIN_SHIFT);
    if (addr == A_CTRL) begin
      acc = AC_CTRL;
    end else if (addr == A_TIMING) begin
      acc = AC_TIMING;
    end else if (addr >= A_WBASE && addr < A_WEND) begin
      case (rel[WIN_SHIFT-1:0])
        WIN_SHIFT'(SUB_DATA): begin acc = AC_FLASH; kind = XK_DATA; end
        WIN_SHIFT'(SUB_ADDR): begin acc = AC_FLASH; kind = XK_ADDR; end
        WIN_SHIFT'(SUB_CMD):  begin acc = AC_FLASH; kind = XK_CMD;  end
        default:              acc = AC_NONE;
      endcase
    end
  end

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_front_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  timing_t tcfg,
  output phase_t  phase,
  output logic    strobe_end,
  output logic    done
);

  logic [TFIELD_W-1:0] cnt;

  function automatic logic [TFIELD_W-1:0] last_idx(input logic [TFIELD_W-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= last_idx(tcfg.setup);
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= last_idx(tcfg.strobe);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_HOLD;
          cnt   <= last_idx(tcfg.hold);
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign strobe_end = (phase == PH_STROBE) && (cnt == '0);
  assign done       = (phase == PH_HOLD) && (cnt == '0);

endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
  import nand_front_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 4,
  parameter int SYNC_DEPTH = 2,
  parameter logic [17:0] TIMING_RST = 18'h01081
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic                 bus_ready,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_BANKS-1:0] flash_ce_n,
  output logic                 flash_cle,
  output logic                 flash_ale,
  output logic                 flash_we_n,
  output logic                 flash_re_n,
  output logic                 flash_wp,
  output logic [7:0]           flash_dq_out,
  output logic                 flash_dq_oe,
  input  logic [7:0]           flash_dq_in,
  input  logic                 flash_rb
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_FLASH, ST_RESP} st_t;

  st_t         st;
  logic [7:0]  ce_sel;
  logic        wp_bit;
  timing_t     tcfg;
  logic [DATA_W-1:0] resp_data;
  xfer_kind_t  cur_kind;
  logic        cur_read;
  logic [7:0]  cur_byte;

  acc_t              dec_acc;
  xfer_kind_t        dec_kind;
  logic [BANK_W-1:0] dec_bank;
  logic              rb_s;
  phase_t            phase;
  logic              strobe_end;
  logic              seq_done;
  logic              accept;
  logic              bank_on;
  logic              seq_start;

  nand_win_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) u_dec (
    .addr(bus_addr), .acc(dec_acc), .kind(dec_kind), .bank(dec_bank)
  );

  nand_rb_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .async_in(flash_rb), .sync_out(rb_s)
  );

  nand_cycle_seq u_seq (
    .clk(clk), .rst(rst), .start(seq_start), .tcfg(tcfg),
    .phase(phase), .strobe_end(strobe_end), .done(seq_done)
  );

  assign accept    = (st == ST_IDLE) && bus_valid;
  assign bank_on   = ce_sel[dec_bank];
  assign seq_start = accept && (dec_acc == AC_FLASH) && bank_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ce_sel    <= '0;
      wp_bit    <= 1'b0;
      tcfg      <= timing_t'(TIMING_RST);
      resp_data <= '0;
      cur_kind  <= XK_DATA;
      cur_read  <= 1'b0;
      cur_byte  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          case (dec_acc)
            AC_CTRL: begin
              resp_data <= DATA_W'({rb_s, wp_bit, ce_sel});
              if (bus_we) begin
                ce_sel <= bus_wdata[7:0];
                wp_bit <= bus_wdata[8];
              end
              st <= ST_RESP;
            end
            AC_TIMING: begin
              resp_data <= DATA_W'(tcfg);
              if (bus_we) tcfg <= timing_t'(bus_wdata[TIMING_W-1:0]);
              st <= ST_RESP;
            end
            AC_FLASH: begin
              cur_kind <= dec_kind;
              cur_read <= ~bus_we;
              cur_byte <= bus_wdata[7:0];
              if (bank_on) begin
                resp_data <= '0;
                st        <= ST_FLASH;
              end else begin
                resp_data <= bus_we ? '0 : DATA_W'(8'hFF);
                st        <= ST_RESP;
              end
            end
            default: begin
              resp_data <= '0;
              st        <= ST_RESP;
            end
          endcase
        end
        ST_FLASH: begin
          if (strobe_end && cur_read) resp_data <= DATA_W'(flash_dq_in);
          if (seq_done) st <= ST_RESP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic active;
  assign active = (phase != PH_IDLE);

  assign bus_ready    = (st == ST_RESP);
  assign bus_rdata    = resp_data;
  assign flash_ce_n   = ~ce_sel[NUM_BANKS-1:0];
  assign flash_wp     = wp_bit;
  assign flash_cle    = active && (cur_kind == XK_CMD);
  assign flash_ale    = active && (cur_kind == XK_ADDR);
  assign flash_we_n   = !((phase == PH_STROBE) && !cur_read);
  assign flash_re_n   = !((phase == PH_STROBE) && cur_read);
  assign flash_dq_oe  = active && !cur_read;
  assign flash_dq_out = cur_byte;

endmodule

// File: rtl/nand_bus_front_chk.sv
module nand_bus_front_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_ready,
  input logic [NUM_BANKS-1:0] flash_ce_n,
  input logic                 flash_cle,
  input logic                 flash_ale,
  input logic                 flash_we_n,
  input logic                 flash_re_n,
  input logic                 flash_dq_oe
);

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!flash_we_n && !flash_re_n)); // R5

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(flash_cle && flash_ale)); // R6

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !flash_re_n |-> !flash_dq_oe); // R8

  AST_READY_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready); // R9

  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    (!flash_we_n || !flash_re_n) |-> (flash_ce_n != {NUM_BANKS{1'b1}})); // R10

endmodule

bind nand_bus_front nand_bus_front_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .bus_ready(bus_ready), .flash_ce_n(flash_ce_n),
  .flash_cle(flash_cle), .flash_ale(flash_ale), .flash_we_n(flash_we_n),
  .flash_re_n(flash_re_n), .flash_dq_oe(flash_dq_oe)
);

// File: tb/nand_bus_front_bench.sv
`timescale 1ns/1ps
module nand_bus_front_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [3:0]  flash_ce_n;
  logic        flash_cle, flash_ale, flash_we_n, flash_re_n, flash_wp;
  logic [7:0]  flash_dq_out;
  logic        flash_dq_oe;
  logic [7:0]  flash_dq_in = 8'h00;
  logic        flash_rb = 1'b1;

  always #5 clk = ~clk;

  nand_bus_front u_nand_bus_front (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .flash_ce_n(flash_ce_n), .flash_cle(flash_cle),
    .flash_ale(flash_ale), .flash_we_n(flash_we_n), .flash_re_n(flash_re_n),
    .flash_wp(flash_wp), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
    .flash_dq_in(flash_dq_in), .flash_rb(flash_rb)
  );

  typedef struct {
    bit       cle, ale, we_n, re_n, oe, rdy, wp;
    bit [3:0] ce_n;
    bit [7:0] dq;
    int       tag;
  } pins_t;

  pins_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit [7:0]  sh_ce = 8'h00;
  bit        sh_wp = 1'b0;
  bit [17:0] sh_tim = 18'h01081;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic pins_t idle_pins();
    pins_t p;
    p.cle = 0; p.ale = 0; p.we_n = 1; p.re_n = 1; p.oe = 0; p.rdy = 0;
    p.wp = sh_wp; p.ce_n = ~sh_ce[3:0]; p.dq = 0; p.tag = 1;
    return p;
  endfunction

  function automatic int eff(input bit [5:0] f);
    return (f == 0) ? 1 : int'(f);
  endfunction

  // per-clock comparison against the expected pin stream
  initial begin
    @(negedge rst);
    forever begin
      pins_t e;
      @(posedge clk); #2;
      if (finished) break;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_pins();
      check(flash_cle == e.cle,   $sformatf("R%0d", e.tag), "cle", 32'(flash_cle), 32'(e.cle));
      check(flash_ale == e.ale,   $sformatf("R%0d", e.tag), "ale", 32'(flash_ale), 32'(e.ale));
      check(flash_we_n == e.we_n, $sformatf("R%0d", e.tag), "we_n", 32'(flash_we_n), 32'(e.we_n));
      check(flash_re_n == e.re_n, $sformatf("R%0d", e.tag), "re_n", 32'(flash_re_n), 32'(e.re_n));
      check(flash_dq_oe == e.oe,  $sformatf("R%0d", e.tag), "dq_oe", 32'(flash_dq_oe), 32'(e.oe));
      if (e.oe)
        check(flash_dq_out == e.dq, $sformatf("R%0d", e.tag), "dq_out", 32'(flash_dq_out), 32'(e.dq));
      check(bus_ready == e.rdy, "R9", "bus_ready", 32'(bus_ready), 32'(e.rdy));
      check(flash_ce_n == e.ce_n, "R2", "ce_n", 32'(flash_ce_n), 32'(e.ce_n));
      check(flash_wp == e.wp, "R2", "wp", 32'(flash_wp), 32'(e.wp));
    end
  end

  task automatic push_phases(input int n, input pins_t p);
    for (int i = 0; i < n; i++) exp_q.push_back(p);
  endtask

  task automatic access(input bit we, input logic [11:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd);
    pins_t base, p;
    int n;
    int rel;
    bit [7:0] new_ce;
    bit new_wp;
    @(negedge clk);
    bus_valid = 1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    base = idle_pins();
    new_ce = sh_ce; new_wp = sh_wp;
    rel = int'(addr) - 'h800;
    if (addr >= 12'h800 && addr < 12'hC00 &&
        (rel % 256 == 0 || rel % 256 == 4 || rel % 256 == 8) &&
        sh_ce[rel / 256]) begin
      p = base;
      p.cle = (rel % 256 == 8);
      p.ale = (rel % 256 == 4);
      p.oe = we; p.dq = wd[7:0];
      p.tag = !we ? 8 : (p.cle ? 5 : (p.ale ? 6 : 7));
      push_phases(eff(sh_tim[5:0]), p);
      p.we_n = !we; p.re_n = we;
      push_phases(eff(sh_tim[11:6]), p);
      p.we_n = 1; p.re_n = 1;
      push_phases(eff(sh_tim[17:12]), p);
    end else if (addr == 12'h000 && we) begin
      new_ce = wd[7:0]; new_wp = wd[8];
    end else if (addr == 12'h004 && we) begin
      sh_tim = wd[17:0];
    end
    p = base; p.rdy = 1; p.ce_n = ~new_ce[3:0]; p.wp = new_wp; p.tag = 9;
    exp_q.push_back(p);
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_ready && n < 500);
    if (n >= 500) check(0, "R9", "handshake timeout", 0, 1);
    rd = bus_rdata;
    bus_valid = 0;
    sh_ce = new_ce; sh_wp = new_wp;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(0, "R9", "watchdog expired", 0, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(flash_ce_n == 4'hF && !flash_wp && !flash_cle && !flash_ale &&
          flash_we_n && flash_re_n && !flash_dq_oe, "R1", "pins after reset",
          {flash_ce_n, flash_wp, flash_cle, flash_ale, flash_we_n, flash_re_n, flash_dq_oe},
          {4'hF, 6'b000110});
    repeat (3) @(negedge clk);
    access(0, 12'h004, 0, rd); check(rd == 32'h1081, "R1", "timing reset", rd, 32'h1081);
    access(0, 12'h000, 0, rd); check(rd == 32'h200, "R1", "ctrl reset", rd, 32'h200);

    // R2 control field
    access(1, 12'h000, 32'h1FF, rd);
    access(0, 12'h000, 0, rd); check(rd == 32'h3FF, "R2", "ctrl readback", rd, 32'h3FF);

    // R3 ready flag
    flash_rb = 0;
    repeat (3) @(negedge clk);
    access(0, 12'h000, 0, rd); check(rd[9] == 0, "R3", "busy seen", rd, 32'h1FF);
    access(1, 12'h000, 32'h201, rd);
    access(0, 12'h000, 0, rd); check(rd == 32'h001, "R3", "bit9 write ignored", rd, 32'h001);
    flash_rb = 1;
    access(0, 12'h000, 0, rd); check(rd == 32'h001, "R3", "two-stage latency", rd, 32'h001);
    access(0, 12'h000, 0, rd); check(rd == 32'h201, "R3", "ready after sync", rd, 32'h201);

    // R5 R6 R7 R8 on bank 0 with write protect set
    access(1, 12'h000, 32'h101, rd);
    access(1, 12'h808, 32'h12345670, rd);  // R5
    access(1, 12'h804, 32'h000000AB, rd);  // R6
    access(1, 12'h800, 32'hFFFFFF3C, rd);  // R7
    flash_dq_in = 8'h5C;
    access(0, 12'h800, 0, rd); check(rd == 32'h5C, "R8", "read byte", rd, 32'h5C);

    // R4 longer timing then zero timing
    access(1, 12'h004, 32'hFFFC2103, rd);
    access(0, 12'h004, 0, rd); check(rd == 32'h2103, "R4", "timing readback", rd, 32'h2103);
    access(1, 12'h808, 32'h90, rd);        // R5 with 3/4/2
    flash_dq_in = 8'hE1;
    access(0, 12'h800, 0, rd); check(rd == 32'hE1, "R8", "read with long strobe", rd, 32'hE1);
    access(1, 12'h004, 32'h0, rd);         // R4 zero fields
    flash_dq_in = 8'h07;
    access(0, 12'h800, 0, rd); check(rd == 32'h07, "R4", "read with zero timing", rd, 32'h07);
    access(1, 12'h804, 32'h66, rd);        // R6
    access(1, 12'h004, 32'h1081, rd);

    // R10 disabled banks
    access(1, 12'h000, 32'h004, rd);
    access(0, 12'h800, 0, rd); check(rd == 32'hFF, "R10", "disabled read", rd, 32'hFF);
    access(1, 12'h908, 32'hFF, rd);        // R10 no strobes
    flash_dq_in = 8'h3A;
    access(0, 12'hA00, 0, rd); check(rd == 32'h3A, "R8", "bank2 read", rd, 32'h3A);
    access(1, 12'hB04, 32'h11, rd);        // R10 bank3 off

    // R11 unmapped offsets
    access(0, 12'h00C, 0, rd); check(rd == 0, "R11", "unmapped read", rd, 0);
    access(1, 12'h0C0, 32'hFFFFFFFF, rd);
    access(0, 12'h000, 0, rd); check(rd == 32'h204, "R11", "ctrl untouched", rd, 32'h204);
    access(0, 12'hA0C, 0, rd); check(rd == 0, "R11", "window hole read", rd, 0);
    access(1, 12'hA10, 32'h55, rd);
    access(0, 12'h004, 0, rd); check(rd == 32'h1081, "R11", "timing untouched", rd, 32'h1081);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule